// File: doc/BRIEF.md
# Address Pointer Auto-Update Unit

This block owns one address pointer that sits beside a memory data window. On every cycle in which the window is read, written or both, it produces the effective address for the access. It also moves the pointer by a programmable stride, following a 4-bit mode code. The codes cover the following behaviours:

- hold
- hold with bursting disabled
- increment after a read or after a write
- decrement after a read or after a write
- a pseudostack, where a read moves the pointer down and a write moves it up
- a true stack, where a read pops upward and a write pushes downward with a pre-decrement

In both stack codes, a read and a write in the same cycle cancel, and the pointer stays where it is.

In the four streaming codes (2 to 5), an optional circular mode keeps the pointer inside a region `[base, limit)`. In the two stack codes, the new pointer is checked against a lower and an upper bound. A push that leaves the bounds raises an overflow indication, and a pop that leaves them raises an underflow indication. In both cases the pointer is not moved, so a handler can recover. The pointer can be loaded directly, and a load overrides any access in the same cycle. Memory, the window contents and the trap handler are outside this block.

Top module: `aupd_unit`

## Requirements
- R1: After reset the pointer is 0 and both the overflow and underflow indications are low.
- R2: When `ld_en` is high, the pointer takes `ld_val` at the next clock whatever the access and mode, and both indications are low in that cycle.
- R3: Mode codes 0 and 1, and every unused code (7, 9 to 15), leave the pointer unchanged and drive the effective address equal to the pointer.
- R4: Mode 2 adds the stride after a read (the read bit is set, whether or not a write is also present), and mode 3 adds it after a write (the write bit is set). The effective address is the old pointer, and the other access type alone has no effect.
- R5: Mode 4 subtracts the stride after a read, and mode 5 subtracts it after a write. The effective address is the old pointer, and the other access type alone has no effect.
- R6: Mode 6 behaves as follows:
  - a read alone subtracts the stride after the access
  - a write alone adds it after the access
  - read and write together leave the pointer unchanged
  - the effective address is always the old pointer
- R7: Mode 8 behaves as follows:
  - a read alone adds the stride after the access, with the old pointer as the effective address
  - a write alone subtracts the stride before the access, so the effective address is the new pointer
  - read and write together leave the pointer unchanged, with the old pointer as the effective address
- R8: With `wrap_en` high in modes 2 to 5, wrapping works as follows:
  - an increment whose result is at or above `limit` has `limit-base` taken off
  - a decrement whose result is below `base`, or that borrows, has `limit-base` added
  - all arithmetic is modulo 2^AW
- R9: In modes 6 and 8, the bounds are checked as follows:
  - an increment whose result carries or exceeds `hi_bound` is out of range
  - a decrement whose result borrows or falls below `lo_bound` is out of range
  - an out-of-range push (a write) raises `ovf` and an out-of-range pop (a read) raises `unf`, in the same cycle
  - when either indication is raised, the pointer keeps its value
- R10: With neither read nor write (and no load), the pointer keeps its value in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load pointer from `ld_val` |
| ld_val | input | AW | Value to load |
| mode | input | 4 | Update mode code |
| rd | input | 1 | Data window read this cycle |
| wr | input | 1 | Data window write this cycle |
| stride | input | AW | Step applied on each update |
| wrap_en | input | 1 | Enable circular wrap in modes 2 to 5 |
| base | input | AW | Lowest address of the circular region |
| limit | input | AW | One past the highest address of the region |
| lo_bound | input | AW | Lowest legal stack pointer |
| hi_bound | input | AW | Highest legal stack pointer |
| eff_addr | output | AW | Address used by this cycle's access |
| ptr | output | AW | Current pointer value |
| ovf | output | 1 | Stack push went out of bounds |
| unf | output | 1 | Stack pop went out of bounds |

## Verification
The bench aims at the following corner cases:
- **Same-cycle read and write in the stack codes.** A design that lets one side win would drift the pointer by one stride.
- **Effective address on a stack push.** Driving the old pointer instead of the pre-decremented one would overwrite the top entry.
- **Wrap boundaries, exactly at `limit` and just under `base`.** An off-by-one compare would leave the pointer one stride outside the ring, or would wrap one step early.
- **Bound violations, including carry and borrow out of the address width.** The pointer must stay put. A unit that updated anyway, or that swapped overflow and underflow, would corrupt the stack or mislead the handler.

A behavioural model in the bench is compared every cycle over directed and random mode, access and stride sequences.

// File: rtl/aupd_pkg.sv
package aupd_pkg;

    typedef enum logic [3:0] {
        MD_HOLD    = 4'd0,
        MD_HOLD_NB = 4'd1,
        MD_RD_INC  = 4'd2,
        MD_WR_INC  = 4'd3,
        MD_RD_DEC  = 4'd4,
        MD_WR_DEC  = 4'd5,
        MD_PSTACK  = 4'd6,
        MD_STACK   = 4'd8
    } mode_t;

    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_INC  = 2'd1,
        MV_DEC  = 2'd2
    } move_t;

    typedef struct packed {
        move_t mv;       // direction of this cycle's update
        logic  pre;      // effective address is the updated value
        logic  push;     // stack push (write side)
        logic  pop;      // stack pop (read side)
        logic  ring;     // circular wrap is allowed
        logic  bounded;  // stack bound check applies
    } plan_t;

endpackage

// File: rtl/aupd_decode.sv
module aupd_decode
    import aupd_pkg::*;
(
    input  logic [3:0] mode,
    input  logic       rd,
    input  logic       wr,
    output plan_t      plan
);

    always_comb begin
        plan.mv      = MV_NONE;
        plan.pre     = 1'b0;
        plan.push    = 1'b0;
        plan.pop     = 1'b0;
        plan.ring    = 1'b0;
        plan.bounded = 1'b0;
        case (mode)
            MD_RD_INC: begin
                plan.ring = 1'b1;
                if (rd) plan.mv = MV_INC;
            end
            MD_WR_INC: begin
                plan.ring = 1'b1;
                if (wr) plan.mv = MV_INC;
            end
            MD_RD_DEC: begin
                plan.ring = 1'b1;
                if (rd) plan.mv = MV_DEC;
            end
            MD_WR_DEC: begin
                plan.ring = 1'b1;
                if (wr) plan.mv = MV_DEC;
            end
            MD_PSTACK: begin
                plan.bounded = 1'b1;
                if (rd && !wr) begin
                    plan.mv  = MV_DEC;
                    plan.pop = 1'b1;
                end else if (wr && !rd) begin
                    plan.mv   = MV_INC;
                    plan.push = 1'b1;
                end
            end
            MD_STACK: begin
                plan.bounded = 1'b1;
                if (rd && !wr) begin
                    plan.mv  = MV_INC;
                    plan.pop = 1'b1;
                end else if (wr && !rd) begin
                    plan.mv   = MV_DEC;
                    plan.pre  = 1'b1;
                    plan.push = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/aupd_arith.sv
module aupd_arith
    import aupd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] stride,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    input  logic          ring_on,
    input  move_t         mv,
    output logic [AW-1:0] cand,
    output logic          carry,
    output logic          borrow
);

    logic [AW:0]   sum_w;
    logic [AW:0]   dif_w;
    logic [AW-1:0] span;
    logic          past_top;
    logic          under_base;

    assign sum_w      = {1'b0, cur} + {1'b0, stride};
    assign dif_w      = {1'b0, cur} - {1'b0, stride};
    assign span       = limit - base;
    assign past_top   = (sum_w >= {1'b0, limit});
    assign under_base = dif_w[AW] || (dif_w[AW-1:0] < base);
    assign carry      = sum_w[AW];
    assign borrow     = dif_w[AW];

    always_comb begin
        unique case (mv)
            MV_INC:  cand = (ring_on && past_top)   ? sum_w[AW-1:0] - span : sum_w[AW-1:0];
            MV_DEC:  cand = (ring_on && under_base) ? dif_w[AW-1:0] + span : dif_w[AW-1:0];
            default: cand = cur;
        endcase
    end

endmodule

// File: rtl/aupd_bounds.sv
module aupd_bounds
    import aupd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  plan_t         plan,
    input  logic [AW-1:0] cand,
    input  logic          carry,
    input  logic          borrow,
    input  logic [AW-1:0] lo_bound,
    input  logic [AW-1:0] hi_bound,
    output logic          viol,
    output logic          ovf_raw,
    output logic          unf_raw
);

    logic out_hi;
    logic out_lo;

    assign out_hi  = carry  || (cand > hi_bound);
    assign out_lo  = borrow || (cand < lo_bound);
    assign viol    = plan.bounded &&
                     (((plan.mv == MV_INC) && out_hi) || ((plan.mv == MV_DEC) && out_lo));
    assign ovf_raw = viol && plan.push;
    assign unf_raw = viol && plan.pop;

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_raw && unf_raw)); // R9

    AST_VIOL_NEEDS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (plan.push || plan.pop)); // R9

endmodule

// File: rtl/aupd_unit.sv
module aupd_unit
    import aupd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_val,
    input  logic [3:0]    mode,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] stride,
    input  logic          wrap_en,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    input  logic [AW-1:0] lo_bound,
    input  logic [AW-1:0] hi_bound,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] ptr,
    output logic          ovf,
    output logic          unf
);

    plan_t         plan;
    logic [AW-1:0] cand;
    logic          carry;
    logic          borrow;
    logic          viol;
    logic          ovf_raw;
    logic          unf_raw;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_d;

    aupd_decode u_decode (
        .mode (mode),
        .rd   (rd),
        .wr   (wr),
        .plan (plan)
    );

    aupd_arith #(.AW(AW)) u_arith (
        .cur     (ptr_q),
        .stride  (stride),
        .base    (base),
        .limit   (limit),
        .ring_on (wrap_en && plan.ring),
        .mv      (plan.mv),
        .cand    (cand),
        .carry   (carry),
        .borrow  (borrow)
    );

    aupd_bounds #(.AW(AW)) u_bounds (
        .clk      (clk),
        .rst_n    (rst_n),
        .plan     (plan),
        .cand     (cand),
        .carry    (carry),
        .borrow   (borrow),
        .lo_bound (lo_bound),
        .hi_bound (hi_bound),
        .viol     (viol),
        .ovf_raw  (ovf_raw),
        .unf_raw  (unf_raw)
    );

    always_comb begin
        if (ld_en)
            ptr_d = ld_val;
        else if ((plan.mv != MV_NONE) && !viol)
            ptr_d = cand;
        else
            ptr_d = ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr      = ptr_q;
    assign eff_addr = plan.pre ? cand : ptr_q;
    assign ovf      = ovf_raw && !ld_en;
    assign unf      = unf_raw && !ld_en;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (ptr == $past(ld_val))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !rd && !wr) |=> (ptr == $past(ptr))); // R10

    AST_STACK_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && rd && wr && (mode == MD_PSTACK || mode == MD_STACK))
        |=> (ptr == $past(ptr))); // R6

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf || unf) |=> (ptr == $past(ptr))); // R9

    AST_HOLD_EFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_HOLD || mode == MD_HOLD_NB) |-> (eff_addr == ptr)); // R3

endmodule

// File: tb/aupd_unit_bench.sv
module aupd_unit_bench;

    localparam int AW   = 16;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_val = '0;
    logic [3:0]    mode = '0;
    logic          rd = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] stride = '0;
    logic          wrap_en = 1'b0;
    logic [AW-1:0] base = '0;
    logic [AW-1:0] limit = '0;
    logic [AW-1:0] lo_bound = '0;
    logic [AW-1:0] hi_bound = '0;
    logic [AW-1:0] eff_addr;
    logic [AW-1:0] ptr;
    logic          ovf;
    logic          unf;

    int compared = 0;
    int mismatched = 0;
    int m_ptr = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    aupd_unit #(.AW(AW)) u_aupd_unit (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
        .mode(mode), .rd(rd), .wr(wr), .stride(stride),
        .wrap_en(wrap_en), .base(base), .limit(limit),
        .lo_bound(lo_bound), .hi_bound(hi_bound),
        .eff_addr(eff_addr), .ptr(ptr), .ovf(ovf), .unf(unf)
    );

    task automatic cmp(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(int md);
        case (md)
            2, 3:    return "R4";
            4, 5:    return "R5";
            6:       return "R6";
            8:       return "R7";
            default: return "R3";
        endcase
    endfunction

    // One access cycle: drive, check combinational outputs, then the pointer.
    task automatic step(string tag, bit l, int lv, int md, bit r, bit w);
        int dir;
        bit pre;
        bit push;
        bit pop;
        bit stk;
        bit ring;
        int cand;
        int raw;
        int span;
        bit bad;
        int e_eff;
        int e_nxt;
        @(negedge clk);
        ld_en = l; ld_val = lv[AW-1:0]; mode = md[3:0]; rd = r; wr = w;
        dir = 0; pre = 0; push = 0; pop = 0; stk = 0; ring = 0;
        if (md == 2 && r)               begin dir = 1;  ring = 1; end
        if (md == 3 && w)               begin dir = 1;  ring = 1; end
        if (md == 4 && r)               begin dir = -1; ring = 1; end
        if (md == 5 && w)               begin dir = -1; ring = 1; end
        if (md == 6 && r && !w)         begin dir = -1; pop = 1;  stk = 1; end
        if (md == 6 && w && !r)         begin dir = 1;  push = 1; stk = 1; end
        if (md == 8 && r && !w)         begin dir = 1;  pop = 1;  stk = 1; end
        if (md == 8 && w && !r)         begin dir = -1; push = 1; stk = 1; pre = 1; end
        span = (int'(limit) - int'(base)) & MASK;
        raw  = m_ptr + dir * int'(stride);
        cand = raw;
        bad  = 0;
        if (ring && wrap_en && dir == 1 && raw >= int'(limit)) cand = raw - span;
        if (ring && wrap_en && dir == -1 && (raw < 0 || raw < int'(base))) cand = raw + span;
        if (stk && dir == 1 && (raw > MASK || raw > int'(hi_bound))) bad = 1;
        if (stk && dir == -1 && (raw < 0 || raw < int'(lo_bound))) bad = 1;
        cand  = cand & MASK;
        e_eff = pre ? cand : m_ptr;
        if (l)                      e_nxt = lv & MASK;
        else if (dir != 0 && !bad)  e_nxt = cand;
        else                        e_nxt = m_ptr;
        #1;
        cmp(tag, "eff_addr", int'(eff_addr), e_eff);
        cmp(tag, "ovf", int'(ovf), int'(!l && bad && push));
        cmp(tag, "unf", int'(unf), int'(!l && bad && pop));
        m_ptr = e_nxt;
        @(posedge clk);
        #1;
        cmp(tag, "ptr", int'(ptr), m_ptr);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                mismatched++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        cmp("R1", "ptr", int'(ptr), 0);
        cmp("R1", "ovf", int'(ovf), 0);
        cmp("R1", "unf", int'(unf), 0);
        rst_n = 1'b1;
        stride = 16'd4;
        base = 16'h0100; limit = 16'h0140;
        lo_bound = 16'h0200; hi_bound = 16'h0240;

        step("R2", 1, 'h1000, 0, 0, 0);
        step("R3", 0, 0, 0, 1, 1);
        step("R3", 0, 0, 1, 1, 0);
        step("R3", 0, 0, 7, 1, 1);
        step("R3", 0, 0, 12, 0, 1);
        step("R4", 0, 0, 2, 1, 0);     // 1004
        step("R4", 0, 0, 2, 0, 1);     // write ignored
        step("R4", 0, 0, 3, 0, 1);     // 1008
        step("R4", 0, 0, 3, 1, 0);     // read ignored
        step("R5", 0, 0, 4, 1, 0);
        step("R5", 0, 0, 5, 0, 1);
        step("R5", 0, 0, 5, 1, 0);
        step("R10", 0, 0, 2, 0, 0);
        step("R6", 0, 0, 6, 1, 0);
        step("R6", 0, 0, 6, 0, 1);
        step("R6", 0, 0, 6, 1, 1);
        step("R7", 0, 0, 8, 1, 0);
        step("R7", 0, 0, 8, 0, 1);     // pre-decrement address
        step("R7", 0, 0, 8, 1, 1);

        wrap_en = 1'b1; stride = 16'h0010;
        step("R2", 1, 'h0130, 0, 0, 0);
        step("R8", 0, 0, 2, 1, 0);     // 0x140 == limit -> 0x100
        step("R8", 0, 0, 4, 1, 0);     // below base -> 0x130
        step("R8", 0, 0, 3, 0, 1);
        step("R2", 1, 'h0008, 0, 0, 0);
        step("R8", 0, 0, 5, 0, 1);     // borrow -> wrap
        wrap_en = 1'b0;

        stride = 16'd4;
        step("R2", 1, 'h0200, 0, 0, 0);
        step("R9", 0, 0, 8, 0, 1);     // push below lo: overflow, held
        step("R9", 0, 0, 6, 1, 0);     // pseudostack pop below lo: underflow
        step("R2", 1, 'h0240, 0, 0, 0);
        step("R9", 0, 0, 8, 1, 0);     // pop above hi: underflow
        step("R9", 0, 0, 6, 0, 1);     // pseudostack push above hi: overflow
        hi_bound = 16'hFFFF;
        step("R2", 1, 'hFFFE, 0, 0, 0);
        step("R9", 0, 0, 8, 1, 0);     // carry out of width
        step("R2", 1, 'h0240, 8, 1, 0);  // load beats a faulting pop
        hi_bound = 16'h0240;

        for (int i = 0; i < 3000; i++) begin
            int md;
            bit l;
            md = $urandom_range(0, 15);
            l  = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 63) == 0) begin
                stride   = 16'($urandom_range(0, 8));
                wrap_en  = 1'($urandom_range(0, 1));
                base     = 16'($urandom_range(0, 'h80));
                limit    = 16'($urandom_range('h80, 'h100));
                lo_bound = 16'($urandom_range(0, 'h40));
                hi_bound = 16'($urandom_range('hC0, 'h120));
            end
            step(l ? "R2" : tag_of(md), l, $urandom_range(0, 'h100), md,
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule